// File: doc/BRIEF.md
# Lockable Address Translation Cache

This block is a fully associative cache of address translations with up to 32 slots. Each slot holds a virtual tag, a physical base, a page size code, an access permission, a preserved flag and a valid flag. A request is translated combinationally in the same cycle. Only the virtual address bits above the slot's page offset take part in the compare. The physical address is the slot's base above that offset, joined with the request's own offset bits below it.

New translations come in through a load port, from a table walker or from a register write. Each load is placed at a victim pointer. The pointer moves only within the slots at or above a programmable lock base, so the slots below the base keep their contents. Two flush commands are provided. The global flush spares slots flagged as preserved. The single-address flush removes every slot that covers the given address. Any slot can be read back by index as a tag word and a data word.

Top module: `tlb_lockdown`

## Requirements
- R1: After reset every slot is invalid with all fields zero, the lock base is 0 and the victim pointer is 0, so the first load lands in slot 0.
- R2: With `lk_req` high, a valid slot hits when its tag equals `lk_va` above the page offset. The offset is 20 bits for size code 0, 16 for code 1, 12 for code 2 and 10 for code 3. `lk_pa` is the slot base above the offset and `lk_va` below it. `lk_miss` is high when no slot hits. With `lk_req` low, both `lk_hit` and `lk_miss` are low.
- R3: Permission code 00 means no access, 01 means read-only, and 10 or 11 mean full access. `lk_fault` is high on a hit whose slot has code 00, or code 01 while `lk_write` is high. It is never high without a hit.
- R4: A load writes tag, base, size, permission and preserved flag into the slot named by the victim pointer and sets it valid. Slots below the lock base are never written by a load.
- R5: Each accepted load moves the victim pointer up by one. From the top slot it returns to the lock base.
- R6: A lock write sets the lock base to `cfg_base` and the victim pointer to `cfg_victim`. A `cfg_victim` below `cfg_base` is raised to `cfg_base`.
- R7: A global flush clears the valid flag of every slot whose preserved flag is 0. Preserved slots stay valid.
- R8: A single-address flush clears the valid flag of every slot whose size-masked tag matches `fl_va`, preserved or not.
- R9: The tag word read at `rd_idx` holds the stored tag in bits [VA_W-1:10], zeros in [9:4], the size code in [3:2], the preserved flag in [1] and the valid flag in [0]. The data word holds the base in [PA_W-1:10], zeros in [9:2] and the permission in [1:0].
- R10: At most one command acts per cycle, chosen in the priority order lock write, global flush, single-address flush, load. Lower-priority commands in the same cycle are dropped.
- R11: When several valid slots hit, the one with the lowest index supplies `lk_pa` and the permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Translation request |
| lk_write | input | 1 | Request is a write access |
| lk_va | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | A valid slot matched |
| lk_miss | output | 1 | Request matched no valid slot |
| lk_fault | output | 1 | Permission fault on the hit |
| lk_pa | output | PA_W | Translated physical address, meaningful only on a hit |
| ld_en | input | 1 | Load a translation at the victim slot |
| ld_va | input | VA_W | Virtual address of the new translation |
| ld_pa | input | PA_W | Physical address of the new translation |
| ld_size | input | 2 | Page size code of the new translation |
| ld_ap | input | 2 | Permission code of the new translation |
| ld_keep | input | 1 | Preserved flag of the new translation |
| cfg_wr | input | 1 | Lock write |
| cfg_base | input | IW | New lock base |
| cfg_victim | input | IW | New victim pointer |
| fl_all | input | 1 | Global flush |
| fl_one | input | 1 | Single-address flush |
| fl_va | input | VA_W | Address for the single-address flush |
| rd_idx | input | IW | Slot index to read back |
| rd_cam | output | VA_W | Tag word of the indexed slot |
| rd_ram | output | PA_W | Data word of the indexed slot |

## Verification
The assertions assume that commands are sampled only on clock edges and that `cfg_base` and `cfg_victim` are always within the slot range. With a power-of-two slot count, the port width alone guarantees the range. The stimulus raises command inputs just after a falling edge and clears them just after the next rising edge, so every command lasts exactly one cycle. The lock values it draws are plain indices of the port width. The stimulus also drives competing commands in the same cycle on purpose. The priority properties are written over the arbitrated command, not the raw inputs, so they stay meaningful in those cycles.

// File: rtl/tlb_lockdown_pkg.sv
package tlb_lockdown_pkg;
   // smallest page offset: every tag is stored from this bit upward
   localparam int MIN_OFS = 10;

   typedef enum logic [1:0] {
      PG_SECT  = 2'd0,
      PG_LARGE = 2'd1,
      PG_SMALL = 2'd2,
      PG_TINY  = 2'd3
   } pg_size_e;

   // page offset width for a size code
   function automatic int unsigned ofs_bits(input logic [1:0] sz);
      case (sz)
         2'd0:    return 20;
         2'd1:    return 16;
         2'd2:    return 12;
         default: return 10;
      endcase
   endfunction

   // permission check: 00 none, 01 read-only, 1x full
   function automatic logic ap_denied(input logic [1:0] ap, input logic wr);
      return (ap == 2'b00) || (ap == 2'b01 && wr);
   endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
   import tlb_lockdown_pkg::*;
#(
   parameter int TW = 22,
   parameter int BW = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_tag,
   input  logic [BW-1:0] wr_base,
   input  logic [1:0]    wr_size,
   input  logic [1:0]    wr_ap,
   input  logic          wr_keep,
   input  logic          kill_soft,
   input  logic          kill_addr,
   input  logic [TW-1:0] kill_tag,
   input  logic [TW-1:0] probe_tag,
   output logic          probe_hit,
   output logic          q_vld,
   output logic          q_keep,
   output logic [1:0]    q_size,
   output logic [1:0]    q_ap,
   output logic [TW-1:0] q_tag,
   output logic [BW-1:0] q_base
);
   logic [TW-1:0] cmp_mask;
   logic          kill_match;

   // only tag bits above the page offset take part in a compare
   assign cmp_mask   = {TW{1'b1}} << (ofs_bits(q_size) - MIN_OFS);
   assign probe_hit  = q_vld && (((probe_tag ^ q_tag) & cmp_mask) == '0);
   assign kill_match = (((kill_tag ^ q_tag) & cmp_mask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_keep <= 1'b0;
         q_size <= '0;
         q_ap   <= '0;
         q_tag  <= '0;
         q_base <= '0;
      end else if (wr_en) begin
         q_vld  <= 1'b1;
         q_keep <= wr_keep;
         q_size <= wr_size;
         q_ap   <= wr_ap;
         q_tag  <= wr_tag;
         q_base <= wr_base;
      end else if (kill_soft && !q_keep) begin
         q_vld <= 1'b0;
      end else if (kill_addr && kill_match) begin
         q_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int NENT = 16,
   parameter int IW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [IW-1:0] cfg_base,
   input  logic [IW-1:0] cfg_vic,
   input  logic          adv,
   output logic [IW-1:0] base_q,
   output logic [IW-1:0] vic_q
);
   localparam logic [IW-1:0] TOP = IW'(NENT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         vic_q  <= '0;
      end else if (cfg_wr) begin
         base_q <= cfg_base;
         vic_q  <= (cfg_vic < cfg_base) ? cfg_base : cfg_vic;
      end else if (adv) begin
         vic_q <= (vic_q == TOP) ? base_q : vic_q + IW'(1);
      end
   end
endmodule

// File: rtl/tlb_lockdown.sv
module tlb_lockdown
   import tlb_lockdown_pkg::*;
#(
   parameter  int NENT = 16,
   parameter  int VA_W = 32,
   parameter  int PA_W = 32,
   localparam int IW   = $clog2(NENT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_req,
   input  logic            lk_write,
   input  logic [VA_W-1:0] lk_va,
   output logic            lk_hit,
   output logic            lk_miss,
   output logic            lk_fault,
   output logic [PA_W-1:0] lk_pa,
   input  logic            ld_en,
   input  logic [VA_W-1:0] ld_va,
   input  logic [PA_W-1:0] ld_pa,
   input  logic [1:0]      ld_size,
   input  logic [1:0]      ld_ap,
   input  logic            ld_keep,
   input  logic            cfg_wr,
   input  logic [IW-1:0]   cfg_base,
   input  logic [IW-1:0]   cfg_victim,
   input  logic            fl_all,
   input  logic            fl_one,
   input  logic [VA_W-1:0] fl_va,
   input  logic [IW-1:0]   rd_idx,
   output logic [VA_W-1:0] rd_cam,
   output logic [PA_W-1:0] rd_ram
);
   localparam int TW = VA_W - MIN_OFS;
   localparam int BW = PA_W - MIN_OFS;

   if (NENT < 2 || NENT > 32 || (NENT & (NENT - 1)) != 0) begin : g_bad_nent
      $error("tlb_lockdown: NENT must be a power of two from 2 to 32");
   end
   if (VA_W < 21 || PA_W < 21) begin : g_bad_width
      $error("tlb_lockdown: address widths must cover a section offset");
   end

   // one command per cycle, in fixed priority
   logic do_fa, do_fo, do_ld;
   assign do_fa = fl_all && !cfg_wr;
   assign do_fo = fl_one && !cfg_wr && !fl_all;
   assign do_ld = ld_en && !cfg_wr && !fl_all && !fl_one;

   logic [IW-1:0] base_q, vic_q;

   tlb_victim #(.NENT(NENT), .IW(IW)) u_vic (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_base(cfg_base),
      .cfg_vic (cfg_victim),
      .adv     (do_ld),
      .base_q  (base_q),
      .vic_q   (vic_q)
   );

   logic [NENT-1:0] wr_vec, hit_vec, vld_vec, keep_vec;
   logic [1:0]      s_size [NENT];
   logic [1:0]      s_ap   [NENT];
   logic [TW-1:0]   s_tag  [NENT];
   logic [BW-1:0]   s_base [NENT];

   for (genvar i = 0; i < NENT; i++) begin : g_slot
      assign wr_vec[i] = do_ld && (vic_q == IW'(i));
      tlb_slot #(.TW(TW), .BW(BW)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_vec[i]),
         .wr_tag   (ld_va[VA_W-1:MIN_OFS]),
         .wr_base  (ld_pa[PA_W-1:MIN_OFS]),
         .wr_size  (ld_size),
         .wr_ap    (ld_ap),
         .wr_keep  (ld_keep),
         .kill_soft(do_fa),
         .kill_addr(do_fo),
         .kill_tag (fl_va[VA_W-1:MIN_OFS]),
         .probe_tag(lk_va[VA_W-1:MIN_OFS]),
         .probe_hit(hit_vec[i]),
         .q_vld    (vld_vec[i]),
         .q_keep   (keep_vec[i]),
         .q_size   (s_size[i]),
         .q_ap     (s_ap[i]),
         .q_tag    (s_tag[i]),
         .q_base   (s_base[i])
      );
   end

   // lowest index wins among multiple hits
   logic [IW-1:0] sel;
   always_comb begin
      sel = '0;
      for (int i = NENT - 1; i >= 0; i--) begin
         if (hit_vec[i]) sel = IW'(i);
      end
   end

   logic            any_hit;
   logic [PA_W-1:0] lo_mask, full_base;
   assign any_hit   = |hit_vec;
   assign lo_mask   = (PA_W'(1) << ofs_bits(s_size[sel])) - PA_W'(1);
   assign full_base = {s_base[sel], {MIN_OFS{1'b0}}};

   assign lk_hit   = lk_req && any_hit;
   assign lk_miss  = lk_req && !any_hit;
   assign lk_fault = lk_hit && ap_denied(s_ap[sel], lk_write);
   assign lk_pa    = (full_base & ~lo_mask) | (PA_W'(lk_va) & lo_mask);

   assign rd_cam = {s_tag[rd_idx], 6'b0, s_size[rd_idx], keep_vec[rd_idx], vld_vec[rd_idx]};
   assign rd_ram = {s_base[rd_idx], 8'b0, s_ap[rd_idx]};
endmodule

// File: rtl/tlb_lockdown_chk.sv
module tlb_lockdown_chk #(
   parameter int NENT = 16,
   parameter int IW   = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_req,
   input logic            lk_hit,
   input logic            lk_miss,
   input logic            lk_fault,
   input logic            ld_en,
   input logic            cfg_wr,
   input logic            fl_all,
   input logic            fl_one,
   input logic [IW-1:0]   base_q,
   input logic [IW-1:0]   vic_q,
   input logic [NENT-1:0] wr_vec,
   input logic [NENT-1:0] vld_vec,
   input logic [NENT-1:0] keep_vec
);
   localparam logic [IW-1:0] TOP = IW'(NENT - 1);

   logic [NENT-1:0] locked;
   assign locked = (NENT'(1) << base_q) - NENT'(1);

   a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));

   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> (!lk_hit && !lk_miss));

   a_r3_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);

   a_r4_unlocked_only: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec) && ((wr_vec & locked) == '0));

   a_r4_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vec != '0) |=> ((vld_vec & $past(wr_vec)) == $past(wr_vec)));

   a_r5_victim_range: assert property (@(posedge clk) disable iff (!rst_n)
      vic_q >= base_q);

   a_r5_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !cfg_wr && !fl_all && !fl_one) |=>
         (vic_q == (($past(vic_q) == TOP) ? $past(base_q) : $past(vic_q) + IW'(1))));

   a_r7_flush_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_all && !cfg_wr) |=> ((vld_vec & ~keep_vec) == '0));

   a_r10_no_load_under_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_all || fl_one || cfg_wr) |-> (wr_vec == '0));
endmodule

bind tlb_lockdown tlb_lockdown_chk #(.NENT(NENT), .IW(IW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lk_req  (lk_req),
   .lk_hit  (lk_hit),
   .lk_miss (lk_miss),
   .lk_fault(lk_fault),
   .ld_en   (ld_en),
   .cfg_wr  (cfg_wr),
   .fl_all  (fl_all),
   .fl_one  (fl_one),
   .base_q  (base_q),
   .vic_q   (vic_q),
   .wr_vec  (wr_vec),
   .vld_vec (vld_vec),
   .keep_vec(keep_vec)
);

// File: tb/sim_tlb_lockdown.sv
`timescale 1ns/1ps
module sim_tlb_lockdown;
   localparam int N  = 16;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        lk_req = 0, lk_write = 0;
   logic [31:0] lk_va = '0;
   logic        lk_hit, lk_miss, lk_fault;
   logic [31:0] lk_pa;
   logic        ld_en = 0, ld_keep = 0;
   logic [31:0] ld_va = '0, ld_pa = '0;
   logic [1:0]  ld_size = '0, ld_ap = '0;
   logic        cfg_wr = 0;
   logic [IW-1:0] cfg_base = '0, cfg_victim = '0;
   logic        fl_all = 0, fl_one = 0;
   logic [31:0] fl_va = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [31:0] rd_cam, rd_ram;

   tlb_lockdown #(.NENT(N), .VA_W(32), .PA_W(32)) u0 (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference model
   logic [21:0] m_tag [N];
   logic [21:0] m_base[N];
   logic [1:0]  m_size[N];
   logic [1:0]  m_ap  [N];
   bit          m_keep[N];
   bit          m_vld [N];
   int          m_lb, m_vic;

   function automatic int ofs(input logic [1:0] s);
      case (s) 2'd0: return 20; 2'd1: return 16; 2'd2: return 12; default: return 10; endcase
   endfunction
   function automatic logic [21:0] tmask(input logic [1:0] s);
      return 22'h3FFFFF << (ofs(s) - 10);
   endfunction
   function automatic bit tmatch(input int i, input logic [31:0] va);
      return ((va[31:10] ^ m_tag[i]) & tmask(m_size[i])) == '0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_tag[i] = '0; m_base[i] = '0; m_size[i] = '0; m_ap[i] = '0;
         m_keep[i] = 0; m_vld[i] = 0;
      end
      m_lb = 0; m_vic = 0;
   endtask

   task automatic model_step();
      if (cfg_wr) begin
         m_lb  = int'(cfg_base);
         m_vic = (cfg_victim < cfg_base) ? int'(cfg_base) : int'(cfg_victim);
      end else if (fl_all) begin
         for (int i = 0; i < N; i++) if (!m_keep[i]) m_vld[i] = 0;
      end else if (fl_one) begin
         for (int i = 0; i < N; i++) if (tmatch(i, fl_va)) m_vld[i] = 0;
      end else if (ld_en) begin
         m_tag[m_vic] = ld_va[31:10]; m_base[m_vic] = ld_pa[31:10];
         m_size[m_vic] = ld_size; m_ap[m_vic] = ld_ap;
         m_keep[m_vic] = ld_keep; m_vld[m_vic] = 1;
         m_vic = (m_vic == N - 1) ? m_lb : m_vic + 1;
      end
   endtask

   task automatic finish_cmd();
      @(posedge clk);
      model_step();
      #1;
      ld_en = 0; cfg_wr = 0; fl_all = 0; fl_one = 0;
   endtask

   task automatic do_load(input logic [31:0] va, input logic [31:0] pa,
                          input logic [1:0] sz, input logic [1:0] ap, input bit keep);
      @(negedge clk);
      ld_en = 1; ld_va = va; ld_pa = pa; ld_size = sz; ld_ap = ap; ld_keep = keep;
      finish_cmd();
   endtask

   task automatic do_cfg(input int b, input int v);
      @(negedge clk);
      cfg_wr = 1; cfg_base = IW'(b); cfg_victim = IW'(v);
      finish_cmd();
   endtask

   task automatic do_flall();
      @(negedge clk); fl_all = 1; finish_cmd();
   endtask

   task automatic do_flone(input logic [31:0] va);
      @(negedge clk); fl_one = 1; fl_va = va; finish_cmd();
   endtask

   task automatic chk_lookup(input logic [31:0] va, input bit wr, input string r);
      bit e_hit; bit e_flt; logic [31:0] e_pa, lm;
      int k;
      @(negedge clk);
      lk_req = 1; lk_va = va; lk_write = wr;
      #2;
      e_hit = 0; k = 0;
      for (int i = N - 1; i >= 0; i--) if (m_vld[i] && tmatch(i, va)) begin e_hit = 1; k = i; end
      e_flt = e_hit && (m_ap[k] == 2'b00 || (m_ap[k] == 2'b01 && wr));
      lm = (32'h1 << ofs(m_size[k])) - 1;
      e_pa = ({m_base[k], 10'b0} & ~lm) | (va & lm);
      n_chk++;
      if (lk_hit !== e_hit || lk_miss !== !e_hit || lk_fault !== e_flt ||
          (e_hit && lk_pa !== e_pa)) begin
         n_bad++;
         $display("FAIL %s lookup va=%h: got hit=%b miss=%b flt=%b pa=%h exp hit=%b miss=%b flt=%b pa=%h",
                  r, va, lk_hit, lk_miss, lk_fault, lk_pa, e_hit, !e_hit, e_flt, e_pa);
      end
      lk_req = 0; lk_write = 0;
   endtask

   task automatic chk_rd(input int idx, input string r);
      logic [31:0] e_cam, e_ram;
      rd_idx = IW'(idx);
      #1;
      e_cam = {m_tag[idx], 6'b0, m_size[idx], m_keep[idx], m_vld[idx]};
      e_ram = {m_base[idx], 8'b0, m_ap[idx]};
      n_chk++;
      if (rd_cam !== e_cam || rd_ram !== e_ram) begin
         n_bad++;
         $display("FAIL %s readback %0d: got cam=%h ram=%h exp cam=%h ram=%h",
                  r, idx, rd_cam, rd_ram, e_cam, e_ram);
      end
   endtask

   task automatic chk_all(input string r);
      @(negedge clk);
      for (int i = 0; i < N; i++) chk_rd(i, r);
   endtask

   function automatic logic [31:0] rnd_va();
      return {12'hA00 + 12'($urandom % 3), 4'($urandom % 2), 4'($urandom % 2),
              2'($urandom % 2), 10'($urandom)};
   endfunction

   initial begin
      #4_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no completion, exp completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset state and first placement
      chk_all("R1");
      chk_lookup(32'hA000_0123, 0, "R1");
      do_load(32'hA010_0000, 32'h1230_0000, 2'd0, 2'd2, 0);
      chk_all("R1");

      // R2: each size code translates with its own offset
      do_load(32'hA020_0000, 32'h4560_0000, 2'd1, 2'd2, 0);
      do_load(32'hA030_3000, 32'h7890_1000, 2'd2, 2'd2, 0);
      do_load(32'hA040_0C00, 32'h3330_0400, 2'd3, 2'd2, 0);
      chk_lookup(32'hA01F_ABCD, 0, "R2");
      chk_lookup(32'hA020_F00F, 0, "R2");
      chk_lookup(32'hA021_0000, 0, "R2");
      chk_lookup(32'hA030_3FFF, 1, "R2");
      chk_lookup(32'hA040_0DEF, 0, "R2");
      chk_lookup(32'hA040_0800, 0, "R2");

      // R3: permission codes
      do_load(32'hB000_0000, 32'h0010_0000, 2'd0, 2'd0, 0);
      do_load(32'hB010_0000, 32'h0020_0000, 2'd0, 2'd1, 0);
      do_load(32'hB020_0000, 32'h0030_0000, 2'd0, 2'd3, 0);
      chk_lookup(32'hB000_0010, 0, "R3");
      chk_lookup(32'hB010_0010, 0, "R3");
      chk_lookup(32'hB010_0010, 1, "R3");
      chk_lookup(32'hB020_0010, 1, "R3");

      // R6: lock write with victim below base
      do_cfg(4, 2);
      do_load(32'hC000_0000, 32'h0C00_0000, 2'd2, 2'd2, 0);
      chk_all("R6");

      // R4 and R5: fill unlocked range and wrap back to base
      for (int i = 0; i < 14; i++)
         do_load(32'hC100_0000 + (i << 12), 32'h0D00_0000 + (i << 12), 2'd2, 2'd1, 0);
      chk_all("R4");
      chk_all("R5");

      // R10: competing commands in one cycle
      @(negedge clk);
      cfg_wr = 1; cfg_base = 4'd0; cfg_victim = 4'd1; ld_en = 1;
      ld_va = 32'hEEE0_0000; ld_pa = 32'h1110_0000; ld_size = 2'd0; ld_ap = 2'd2; ld_keep = 0;
      finish_cmd();
      @(negedge clk);
      fl_one = 1; fl_va = 32'hC000_0000; ld_en = 1;
      finish_cmd();
      chk_all("R10");
      chk_lookup(32'hEEE0_0000, 0, "R10");

      // R11: overlapping slots, lowest index wins
      do_cfg(0, 0);
      do_load(32'hD000_0000, 32'h5000_0000, 2'd0, 2'd2, 0);
      do_load(32'hD000_0400, 32'h6000_0400, 2'd3, 2'd1, 0);
      chk_lookup(32'hD000_0456, 1, "R11");

      // R7: global flush spares preserved slots
      do_load(32'hE000_0000, 32'h7000_0000, 2'd0, 2'd2, 1);
      do_flall();
      chk_all("R7");
      chk_lookup(32'hE000_1234, 0, "R7");

      // R8: single-address flush hits preserved and all covering slots
      do_load(32'hE010_0000, 32'h7100_0000, 2'd3, 2'd2, 0);
      do_flone(32'hE000_0ABC);
      do_flone(32'hE01F_F000);
      chk_all("R8");
      chk_lookup(32'hE000_0000, 0, "R8");

      // random mix, checked against the model; R9 readback
      for (int it = 0; it < 600; it++) begin
         int op;
         op = $urandom % 20;
         if (op < 8)
            do_load(rnd_va(), $urandom, 2'($urandom), 2'($urandom), bit'($urandom % 4 == 0));
         else if (op < 15)
            chk_lookup(rnd_va(), bit'($urandom % 2), "R2");
         else if (op < 17)
            do_flone(rnd_va());
         else if (op == 17)
            do_flall();
         else if (op == 18)
            do_cfg($urandom % N, $urandom % N);
         else begin
            @(negedge clk);
            chk_rd($urandom % N, "R9");
         end
      end
      chk_all("R9");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule